// File: doc/BRIEF.md
# Linked-List Descriptor Autoload Controller

This block sequences a single DMA channel through a chain of descriptors held in memory. The host first writes an initial channel configuration and the address of the first list element. It then issues a start command. From that point the controller runs without processor help. It fetches a descriptor, merges its payload into the channel configuration, and hands the merged configuration to an external transfer engine with a start pulse. When the engine reports completion, the controller follows the next-pointer to the following element and repeats.

The configuration has six words: source address, destination address, element count, frame count, source access mode and destination access mode. Descriptors come in three lengths. The longest replaces all six words. A medium one replaces the first four. The shortest replaces only the two addresses. Any word that a descriptor does not carry keeps its value.

A start may be fast or non-fast:
- A fast start loads the first element before the first transfer.
- A non-fast start first runs a transfer with the configuration already present, and only then fetches the first element.

A pause flag in a descriptor holds the channel after that descriptor is loaded, until the host resumes it. When the transfer of the descriptor marked as list end completes, the controller stops. It then raises a sticky interrupt, which the host clears.

Top module: `ll_autoload_ctrl`

## Requirements
- R1: After each transfer completion (`xfer_done`) the controller fetches the element named by the previously loaded header's next-pointer and pulses `xfer_start` again, with no host command, unless the end flag was set.
- R2: A start with `cmd_fast`=0 pulses `xfer_start` with the host-written configuration before any memory read. The header at the list-head address is read only after that transfer's `xfer_done`.
- R3: A start with `cmd_fast`=1 reads the header at the list-head address and loads its payload before the first `xfer_start`, and that transfer uses the loaded values.
- R4: If a loaded header has its pause bit (bit 2) set, `status` becomes paused (3) and no `xfer_start` is issued until `cmd_resume`. After `cmd_resume`, `xfer_start` is issued.
- R5: While a transfer runs (`status`=2), the controller stays in that state until `xfer_done`, and `cmd_resume` has no effect.
- R6: Header bits [1:0] give the type. Type 1 has 6 payload words, type 2 has 4, type 3 has 2, and type 0 has none. Payload word k sits at the header address + 4·(k+1) and is written into configuration word k.
- R7: Configuration words beyond a descriptor's payload keep their previous values for the next transfer.
- R8: Header bit 3 is the end flag. Bits [31:4] with four zero bits appended form the next-element byte address. When the transfer of an end-flagged descriptor completes, `status` becomes done (4) and `irq` rises.
- R9: `irq` stays high until the host pulses `irq_clear`, which drops it on the next clock.
- R10: While the controller is not idle or done, `cmd_start` and host register writes are ignored.
- R11: `status` encodes idle=0, fetching=1, transferring=2, paused=3, done=4. After reset, `status`=0 and `irq`, `mem_req` and `xfer_start` are 0.
- R12: Descriptor reads are single-word and one at a time: `mem_req` is a one-cycle pulse with `mem_addr`, and the next request waits for `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_idx | input | IW (3) | Target: 0..5 config word, 6 list-head address |
| host_wdata | input | DW | Host write data |
| cmd_start | input | 1 | Start pulse |
| cmd_fast | input | 1 | Selects fast start, sampled with `cmd_start` |
| cmd_resume | input | 1 | Resume pulse for a paused channel |
| irq_clear | input | 1 | Clears the interrupt |
| status | output | 3 | Channel state code |
| irq | output | 1 | Sticky end-of-list interrupt |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| xfer_start | output | 1 | Transfer start pulse to the engine |
| xfer_cfg | output | NCFG·DW | Configuration words, word k at bits [k·DW +: DW] |
| xfer_done | input | 1 | Transfer completion pulse from the engine |

## Verification
The bench builds the block with its defaults: DW = AW = 32 and NCFG = 6. With six words, a type-1 descriptor replaces the whole configuration. The type-2 and type-3 lists then leave visible untouched words, so retention can be observed at `xfer_cfg`. The 32-bit header width places the next-pointer at bits [31:4], which lets short lists sit at distinct 16-byte-aligned addresses in a 128-word bench memory. Both start modes are covered, as well as a paused descriptor and a header-only descriptor.

// File: rtl/ll_autoload_pkg.sv
package ll_autoload_pkg;

  // Payload lengths per descriptor type (configuration words replaced)
  localparam int unsigned LEN_TYPE1 = 6;
  localparam int unsigned LEN_TYPE2 = 4;
  localparam int unsigned LEN_TYPE3 = 2;

  // Channel state; the code doubles as the host-visible status
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_XFER  = 3'd2,
    ST_PAUSE = 3'd3,
    ST_DONE  = 3'd4
  } ch_state_t;

  function automatic int unsigned payload_len(input logic [1:0] kind);
    case (kind)
      2'd1:    return LEN_TYPE1;
      2'd2:    return LEN_TYPE2;
      2'd3:    return LEN_TYPE3;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ll_cfg_regs.sv
module ll_cfg_regs #(
  parameter int DW   = 32,
  parameter int NCFG = 6,
  parameter int IW   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [IW-1:0]      host_idx,
  input  logic [DW-1:0]      host_data,
  input  logic               ld_we,
  input  logic [IW-1:0]      ld_idx,
  input  logic [DW-1:0]      ld_data,
  output logic [NCFG*DW-1:0] cfg_flat
);

  // One register per configuration word; descriptor loads take priority
  for (genvar g = 0; g < NCFG; g++) begin : g_word
    logic [DW-1:0] word_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (ld_we && ld_idx == IW'(g)) begin
        word_q <= ld_data;
      end else if (host_we && host_idx == IW'(g)) begin
        word_q <= host_data;
      end
    end

    assign cfg_flat[g*DW +: DW] = word_q;
  end

endmodule

// File: rtl/ll_desc_fetch.sv
module ll_desc_fetch
  import ll_autoload_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int NCFG = 6,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] base,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          ld_we,
  output logic [IW-1:0] ld_idx,
  output logic [DW-1:0] ld_data,
  output logic [AW-1:0] hdr_next,
  output logic          hdr_pause,
  output logic          hdr_last,
  output logic          done
);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_t;

  fst_t          fst;
  logic [AW-1:0] base_q;
  logic [IW-1:0] widx;     // 0 = header, k = payload word k-1
  logic [IW-1:0] nwords;
  logic [IW-1:0] hdr_len;

  assign hdr_len = IW'(payload_len(mem_rdata[1:0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      fst       <= F_IDLE;
      base_q    <= '0;
      widx      <= '0;
      nwords    <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      ld_we     <= 1'b0;
      ld_idx    <= '0;
      ld_data   <= '0;
      hdr_next  <= '0;
      hdr_pause <= 1'b0;
      hdr_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      ld_we   <= 1'b0;
      done    <= 1'b0;
      case (fst)
        F_IDLE: begin
          if (go) begin
            base_q <= base;
            widx   <= '0;
            fst    <= F_REQ;
          end
        end
        F_REQ: begin
          mem_req  <= 1'b1;
          mem_addr <= base_q + AW'({widx, 2'b00});
          fst      <= F_WAIT;
        end
        F_WAIT: begin
          if (mem_rvalid) begin
            if (widx == '0) begin
              nwords    <= hdr_len;
              hdr_pause <= mem_rdata[2];
              hdr_last  <= mem_rdata[3];
              hdr_next  <= {mem_rdata[AW-1:4], 4'b0000};
              if (hdr_len == '0) begin
                done <= 1'b1;
                fst  <= F_IDLE;
              end else begin
                widx <= IW'(1);
                fst  <= F_REQ;
              end
            end else begin
              ld_we   <= 1'b1;
              ld_idx  <= widx - 1'b1;
              ld_data <= mem_rdata;
              if (widx == nwords) begin
                done <= 1'b1;
                fst  <= F_IDLE;
              end else begin
                widx <= widx + 1'b1;
                fst  <= F_REQ;
              end
            end
          end
        end
        default: fst <= F_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ll_seq_fsm.sv
module ll_seq_fsm
  import ll_autoload_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_start,
  input  logic          cmd_fast,
  input  logic          cmd_resume,
  input  logic          irq_clear,
  input  logic [AW-1:0] list_head,
  input  logic          fetch_done,
  input  logic [AW-1:0] hdr_next,
  input  logic          hdr_pause,
  input  logic          hdr_last,
  input  logic          xfer_done,
  output logic          fetch_go,
  output logic [AW-1:0] fetch_base,
  output logic          xfer_start,
  output ch_state_t     state,
  output logic          irq,
  output logic          host_ok
);

  logic          last_q;
  logic [AW-1:0] next_q;

  assign host_ok = (state == ST_IDLE) || (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      irq        <= 1'b0;
      last_q     <= 1'b0;
      next_q     <= '0;
      fetch_go   <= 1'b0;
      fetch_base <= '0;
      xfer_start <= 1'b0;
    end else begin
      fetch_go   <= 1'b0;
      xfer_start <= 1'b0;
      if (irq_clear) irq <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (cmd_start) begin
            last_q <= 1'b0;
            if (cmd_fast) begin
              fetch_go   <= 1'b1;
              fetch_base <= list_head;
              state      <= ST_FETCH;
            end else begin
              next_q     <= list_head;
              xfer_start <= 1'b1;
              state      <= ST_XFER;
            end
          end
        end
        ST_FETCH: begin
          if (fetch_done) begin
            last_q <= hdr_last;
            next_q <= hdr_next;
            if (hdr_pause) begin
              state <= ST_PAUSE;
            end else begin
              xfer_start <= 1'b1;
              state      <= ST_XFER;
            end
          end
        end
        ST_PAUSE: begin
          if (cmd_resume) begin
            xfer_start <= 1'b1;
            state      <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (xfer_done) begin
            if (last_q) begin
              state <= ST_DONE;
              irq   <= 1'b1;
            end else begin
              fetch_go   <= 1'b1;
              fetch_base <= next_q;
              state      <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ll_autoload_ctrl.sv
module ll_autoload_ctrl
  import ll_autoload_pkg::*;
#(
  parameter  int DW   = 32,
  parameter  int AW   = 32,
  parameter  int NCFG = 6,
  localparam int IW   = $clog2(NCFG + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [IW-1:0]      host_idx,
  input  logic [DW-1:0]      host_wdata,
  input  logic               cmd_start,
  input  logic               cmd_fast,
  input  logic               cmd_resume,
  input  logic               irq_clear,
  output logic [2:0]         status,
  output logic               irq,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  input  logic               mem_rvalid,
  input  logic [DW-1:0]      mem_rdata,
  output logic               xfer_start,
  output logic [NCFG*DW-1:0] xfer_cfg,
  input  logic               xfer_done
);

  ch_state_t     state;
  logic          host_ok;
  logic          host_cfg_we;
  logic [AW-1:0] list_head;
  logic          fetch_go;
  logic [AW-1:0] fetch_base;
  logic          fetch_done;
  logic          ld_we;
  logic [IW-1:0] ld_idx;
  logic [DW-1:0] ld_data;
  logic [AW-1:0] hdr_next;
  logic          hdr_pause;
  logic          hdr_last;

  assign status      = state;
  assign host_cfg_we = host_we && host_ok && (host_idx < IW'(NCFG));

  always_ff @(posedge clk) begin
    if (rst) begin
      list_head <= '0;
    end else if (host_we && host_ok && host_idx == IW'(NCFG)) begin
      list_head <= host_wdata[AW-1:0];
    end
  end

  ll_cfg_regs #(.DW(DW), .NCFG(NCFG), .IW(IW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_cfg_we),
    .host_idx  (host_idx),
    .host_data (host_wdata),
    .ld_we     (ld_we),
    .ld_idx    (ld_idx),
    .ld_data   (ld_data),
    .cfg_flat  (xfer_cfg)
  );

  ll_desc_fetch #(.DW(DW), .AW(AW), .NCFG(NCFG), .IW(IW)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .go         (fetch_go),
    .base       (fetch_base),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .ld_we      (ld_we),
    .ld_idx     (ld_idx),
    .ld_data    (ld_data),
    .hdr_next   (hdr_next),
    .hdr_pause  (hdr_pause),
    .hdr_last   (hdr_last),
    .done       (fetch_done)
  );

  ll_seq_fsm #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .cmd_fast   (cmd_fast),
    .cmd_resume (cmd_resume),
    .irq_clear  (irq_clear),
    .list_head  (list_head),
    .fetch_done (fetch_done),
    .hdr_next   (hdr_next),
    .hdr_pause  (hdr_pause),
    .hdr_last   (hdr_last),
    .xfer_done  (xfer_done),
    .fetch_go   (fetch_go),
    .fetch_base (fetch_base),
    .xfer_start (xfer_start),
    .state      (state),
    .irq        (irq),
    .host_ok    (host_ok)
  );

endmodule

// File: rtl/ll_autoload_chk.sv
module ll_autoload_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] status,
  input logic       irq,
  input logic       irq_clear,
  input logic       cmd_resume,
  input logic       mem_req,
  input logic       xfer_start,
  input logic       xfer_done
);

  AST_START_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> status == 3'd2);                                   // R1

  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd3 && !cmd_resume) |=> (status == 3'd3 && !xfer_start)); // R4

  AST_XFER_UNBROKEN: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd2 && !xfer_done) |=> status == 3'd2);               // R5

  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> status == 3'd4);                                   // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clear) |=> irq);                                     // R9

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
    status <= 3'd4);                                                  // R11

  AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);                                            // R12

endmodule

bind ll_autoload_ctrl ll_autoload_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .status     (status),
  .irq        (irq),
  .irq_clear  (irq_clear),
  .cmd_resume (cmd_resume),
  .mem_req    (mem_req),
  .xfer_start (xfer_start),
  .xfer_done  (xfer_done)
);

// File: tb/ll_autoload_ctrl_test.sv
module ll_autoload_ctrl_test;

  localparam int DW = 32;
  localparam int AW = 32;
  localparam int NCFG = 6;
  localparam int IW = 3;
  localparam int ENGINE_LAT = 7;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               host_we = 1'b0;
  logic [IW-1:0]      host_idx = '0;
  logic [DW-1:0]      host_wdata = '0;
  logic               cmd_start = 1'b0;
  logic               cmd_fast = 1'b0;
  logic               cmd_resume = 1'b0;
  logic               irq_clear = 1'b0;
  logic [2:0]         status;
  logic               irq;
  logic               mem_req;
  logic [AW-1:0]      mem_addr;
  logic               mem_rvalid = 1'b0;
  logic [DW-1:0]      mem_rdata = '0;
  logic               xfer_start;
  logic [NCFG*DW-1:0] xfer_cfg;
  logic               xfer_done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  ll_autoload_ctrl uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_idx(host_idx),
    .host_wdata(host_wdata), .cmd_start(cmd_start), .cmd_fast(cmd_fast),
    .cmd_resume(cmd_resume), .irq_clear(irq_clear), .status(status),
    .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_start(xfer_start), .xfer_cfg(xfer_cfg), .xfer_done(xfer_done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int reqs_seen = 0;
  int starts_seen = 0;
  int reqs_at_first = -1;
  bit finished = 1'b0;

  logic [31:0]        mem [0:127];
  logic [NCFG*DW-1:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [NCFG*DW-1:0] pack6(input logic [31:0] w0, w1, w2, w3, w4, w5);
    return {w5, w4, w3, w2, w1, w0};
  endfunction

  function automatic logic [31:0] hdr(input logic [31:0] nxt, input logic [1:0] kind,
                                      input bit pause, input bit last);
    return {nxt[31:4], last, pause, kind};
  endfunction

  // Driver side of the scoreboard
  task automatic push_exp(input logic [NCFG*DW-1:0] v);
    exp_q.push_back(v);
  endtask

  // Monitor: compares every transfer launch against the expected queue
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_start) begin
        starts_seen++;
        if (starts_seen == 1) reqs_at_first = reqs_seen;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", $sformatf("unexpected transfer, actual cfg %h expected none", xfer_cfg));
        end else begin
          logic [NCFG*DW-1:0] e;
          e = exp_q.pop_front();
          chk(xfer_cfg == e, "R6/R7",
              $sformatf("transfer cfg actual %h expected %h", xfer_cfg, e));
        end
      end
    end
  end

  // Memory model: two-cycle read latency
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [AW-1:0] a;
        a = mem_addr;
        reqs_seen++;
        @(negedge clk);
        @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = mem[a[8:2]];
      end
    end
  end

  // Transfer engine: completes a fixed number of cycles after each start
  initial begin
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (xfer_start) begin
        repeat (ENGINE_LAT) @(negedge clk);
        xfer_done = 1'b1;
      end
    end
  end

  task automatic host_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_idx = IW'(idx); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic pulse_start(input bit fast);
    @(negedge clk);
    cmd_start = 1'b1; cmd_fast = fast;
    @(negedge clk);
    cmd_start = 1'b0; cmd_fast = 1'b0;
  endtask

  task automatic pulse_resume();
    @(negedge clk);
    cmd_resume = 1'b1;
    @(negedge clk);
    cmd_resume = 1'b0;
  endtask

  task automatic wait_status(input logic [2:0] s, input string req);
    int n = 0;
    while (status !== s && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(status === s, req, $sformatf("status actual %0d expected %0d", status, s));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not end, actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    // List A at 0x40: type 3 -> 0x80: type 2 with end flag
    mem[16] = hdr(32'h80, 2'd3, 1'b0, 1'b0);
    mem[17] = 32'h1111_0001; mem[18] = 32'h2222_0001;
    mem[32] = hdr(32'h0, 2'd2, 1'b0, 1'b1);
    mem[33] = 32'h1111_0002; mem[34] = 32'h2222_0002;
    mem[35] = 32'h0000_0040; mem[36] = 32'h0000_0003;
    // List B at 0xC0: type 1 paused -> 0x100: header-only with end flag
    mem[48] = hdr(32'h100, 2'd1, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) mem[49+k] = 32'hB000_0000 + k;
    mem[64] = hdr(32'h0, 2'd0, 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(status == 3'd0, "R11", $sformatf("status actual %0d expected 0", status));
    chk(irq == 1'b0, "R11", $sformatf("irq actual %0b expected 0", irq));
    chk(mem_req == 1'b0, "R11", $sformatf("mem_req actual %0b expected 0", mem_req));
    chk(xfer_start == 1'b0, "R11", $sformatf("xfer_start actual %0b expected 0", xfer_start));

    // ---- Non-fast run over list A ----
    for (int k = 0; k < 6; k++) host_write(k, 32'hA000_0000 + k);
    host_write(6, 32'h40);
    push_exp(pack6(32'hA000_0000, 32'hA000_0001, 32'hA000_0002,
                   32'hA000_0003, 32'hA000_0004, 32'hA000_0005));
    push_exp(pack6(32'h1111_0001, 32'h2222_0001, 32'hA000_0002,
                   32'hA000_0003, 32'hA000_0004, 32'hA000_0005));
    push_exp(pack6(32'h1111_0001, 32'h2222_0002, 32'h0000_0040,
                   32'h0000_0003, 32'hA000_0004, 32'hA000_0005) & 0 |
             pack6(32'h1111_0002, 32'h2222_0002, 32'h0000_0040,
                   32'h0000_0003, 32'hA000_0004, 32'hA000_0005));
    starts_seen = 0; reqs_seen = 0; reqs_at_first = -1;
    pulse_start(1'b0);
    wait_status(3'd2, "R2");
    // R10: start and host writes during a transfer are ignored
    pulse_start(1'b1);
    chk(status == 3'd2, "R10", $sformatf("status after busy start actual %0d expected 2", status));
    host_write(5, 32'hDEAD_BEEF);
    host_write(6, 32'h0000_00C0);
    chk(reqs_at_first == 0, "R2",
        $sformatf("reads before first transfer actual %0d expected 0", reqs_at_first));
    wait_status(3'd4, "R8");
    chk(irq == 1'b1, "R8", $sformatf("irq at end actual %0b expected 1", irq));
    chk(starts_seen == 3, "R1", $sformatf("transfers actual %0d expected 3", starts_seen));
    chk(reqs_seen == 8, "R6", $sformatf("descriptor reads actual %0d expected 8", reqs_seen));
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R9", $sformatf("irq before clear actual %0b expected 1", irq));
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
    chk(irq == 1'b0, "R9", $sformatf("irq after clear actual %0b expected 0", irq));
    chk(exp_q.size() == 0, "R1", $sformatf("pending transfers actual %0d expected 0", exp_q.size()));

    // ---- Fast run over list B with pause ----
    host_write(6, 32'hC0);
    push_exp(pack6(32'hB000_0000, 32'hB000_0001, 32'hB000_0002,
                   32'hB000_0003, 32'hB000_0004, 32'hB000_0005));
    push_exp(pack6(32'hB000_0000, 32'hB000_0001, 32'hB000_0002,
                   32'hB000_0003, 32'hB000_0004, 32'hB000_0005));
    starts_seen = 0; reqs_seen = 0; reqs_at_first = -1;
    pulse_start(1'b1);
    wait_status(3'd3, "R4");
    repeat (10) @(negedge clk);
    chk(status == 3'd3, "R4", $sformatf("status while paused actual %0d expected 3", status));
    chk(starts_seen == 0, "R4", $sformatf("transfers while paused actual %0d expected 0", starts_seen));
    chk(reqs_seen == 7, "R3", $sformatf("reads before first transfer actual %0d expected 7", reqs_seen));
    pulse_resume();
    wait_status(3'd2, "R4");
    pulse_resume();
    chk(status == 3'd2, "R5", $sformatf("status after resume in transfer actual %0d expected 2", status));
    wait_status(3'd4, "R8");
    chk(reqs_at_first == 7, "R3",
        $sformatf("reads at first transfer actual %0d expected 7", reqs_at_first));
    chk(starts_seen == 2, "R1", $sformatf("transfers actual %0d expected 2", starts_seen));
    chk(irq == 1'b1, "R8", $sformatf("irq at end actual %0b expected 1", irq));
    chk(exp_q.size() == 0, "R7", $sformatf("pending transfers actual %0d expected 0", exp_q.size()));
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0 && status == 3'd4, "R12",
        $sformatf("idle after end actual req %0b status %0d expected 0/4", mem_req, status));
    finish_run();
  end

endmodule